// File: doc/BRIEF.md
# Dual-Channel Converter Output Stager

This block is the digital back end of a two-channel 8-bit sampling converter. Each channel has its own encode clock. On every rising encode edge a channel captures an ideal offset-binary code and moves it through a fixed pipeline. The code reaches the channel's output register four encode edges after capture. The output register applies the selected number format to each sample as it is loaded: offset binary passes through unchanged, and two's complement inverts the most significant bit.

A two-bit mode selector `mode_sel` (bit 1 is the first selector, bit 0 the second) picks one of four modes: both channels asleep, only channel B asleep, normal, or aligned. In aligned mode, channel B's result is retimed by a register clocked on the falling edge of B's encode clock. B's data therefore moves half an encode period late, which puts it on channel A's rising edge when the two clocks run in antiphase. A sleeping channel drops its output enable, which models high-impedance pads, and ignores its encode edges.

Each lane runs a three-state controller: `LN_SLEEP`, `LN_WAKE` and `LN_LIVE`. Transitions:
- Reset puts a lane in `LN_WAKE` with only the pipeline-refill count pending.
- In any state, an encode edge seen while the lane is asleep moves it to `LN_SLEEP`.
- From `LN_SLEEP`, the first edge while awake loads both the refill count and the 15-edge recovery count and moves to `LN_WAKE`.
- `LN_WAKE` moves to `LN_LIVE` on the edge that clears the last outstanding count.

The data-valid output is high only in `LN_LIVE`.

Top module: `dual_adc_stager`

## Requirements
- R1: A code present on a channel's input at encode rising edge n appears on that channel's data output just after rising edge n+4.
- R2: With `fmt_twos` low, the output code equals the input code (offset binary).
- R3: With `fmt_twos` high, the output code equals the input code with bit 7 inverted (two's complement), e.g. input 0x84 gives 0x04.
- R4: `mode_sel` = 2'b00 drives `oe_a` and `oe_b` low, and both data outputs keep their value.
- R5: `mode_sel` = 2'b01 drives `oe_b` low with channel B frozen, while channel A runs normally with `oe_a` high.
- R6: `mode_sel` = 2'b10 drives both enables high, and with a shared encode clock both channels update on the same rising edge with four-edge latency.
- R7: `mode_sel` = 2'b11 makes `dout_b` and `valid_b` change on the falling edge of `enc_b_clk`, half a period after B's rising edge. With `enc_b_clk` the inverse of `enc_a_clk`, `dout_b` therefore changes on the rising edge of `enc_a_clk`.
- R8: While a channel is in standby its encode edges are ignored and its data output holds its last value.
- R9: After reset, `valid_a` and `valid_b` stay low through the fourth encode edge and rise after the fifth, when the first real sample has reached the output.
- R10: A channel's valid output falls after the first encode edge it sees in standby. After standby is released, valid stays low through the 14th encode edge and rises after the 15th.
- R11: Asynchronous active-low `rst_n` immediately forces both data outputs to 0 and both valid outputs low.
- R12: Each channel is timed only by its own encode clock. With an inverted B clock in normal mode, channel B updates on `enc_b_clk` rising edges, half an `enc_a_clk` period away from channel A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_a_clk | input | 1 | Encode clock of channel A |
| enc_b_clk | input | 1 | Encode clock of channel B |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode: 00 both asleep, 01 B asleep, 10 normal, 11 B aligned |
| fmt_twos | input | 1 | 0 = offset binary, 1 = two's complement output |
| code_a | input | 8 | Quantised offset-binary code, channel A |
| code_b | input | 8 | Quantised offset-binary code, channel B |
| oe_a | output | 1 | Output enable, channel A (low = high impedance) |
| dout_a | output | 8 | Formatted output data, channel A |
| valid_a | output | 1 | Channel A data valid |
| oe_b | output | 1 | Output enable, channel B (low = high impedance) |
| dout_b | output | 8 | Formatted output data, channel B |
| valid_b | output | 1 | Channel B data valid |

## Verification
The bench checks channel B's output both just after A's rising edge and just before the next one. Across the two clock phasings this separates a correct half-cycle retime from a retime applied in the wrong mode or on the wrong edge, since either mistake shifts B by one sample at one of the two points. A ramp that crosses 0x80 catches a format stage that inverts the wrong bit or ignores the select. The recovery test counts edges after standby is released and checks the 14th and 15th. A design that gated valid only on the pipeline refill would rise at the fifth edge, and an off-by-one counter would miss by one. Frozen-output checks during standby catch a pipeline that keeps shifting while asleep.

// File: rtl/stager_pkg.sv
`timescale 1ns/1ps
package stager_pkg;

    typedef enum logic [1:0] {
        MODE_ALL_OFF = 2'b00,
        MODE_B_OFF   = 2'b01,
        MODE_NORMAL  = 2'b10,
        MODE_ALIGN   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        LN_SLEEP = 2'd0,
        LN_WAKE  = 2'd1,
        LN_LIVE  = 2'd2
    } lane_state_e;

endpackage

// File: rtl/stager_mode_dec.sv
`timescale 1ns/1ps
module stager_mode_dec
    import stager_pkg::*;
(
    input  logic [1:0] mode_sel,
    output logic       run_a,
    output logic       run_b,
    output logic       align_b
);

    always_comb begin
        unique case (mode_e'(mode_sel))
            MODE_ALL_OFF: begin run_a = 1'b0; run_b = 1'b0; align_b = 1'b0; end
            MODE_B_OFF:   begin run_a = 1'b1; run_b = 1'b0; align_b = 1'b0; end
            MODE_NORMAL:  begin run_a = 1'b1; run_b = 1'b1; align_b = 1'b0; end
            MODE_ALIGN:   begin run_a = 1'b1; run_b = 1'b1; align_b = 1'b1; end
        endcase
    end

endmodule

// File: rtl/stager_lane.sv
`timescale 1ns/1ps
module stager_lane
    import stager_pkg::*;
#(
    parameter int W     = 8,
    parameter int LAT   = 4,
    parameter int RECOV = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         fmt_twos,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] data_out,
    output logic         valid_out
);

    localparam int FILL    = LAT + 1;
    localparam int MAXC    = (FILL > RECOV) ? FILL : RECOV;
    localparam int CW      = $clog2(MAXC + 1);
    localparam bit INSTANT = (FILL <= 1) && (RECOV <= 1);

    lane_state_e   state, nxt;
    logic [CW-1:0] fill_left, rec_left, fill_nxt, rec_nxt;
    logic          capture;
    logic [W-1:0]  pipe [LAT+1];

    function automatic logic [W-1:0] apply_fmt(input logic [W-1:0] c, input logic twos);
        return twos ? {~c[W-1], c[W-2:0]} : c;
    endfunction

    function automatic logic [CW-1:0] dec_sat(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    // State and recovery counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= LN_WAKE;
            fill_left <= CW'(FILL);
            rec_left  <= '0;
        end else begin
            state     <= nxt;
            fill_left <= fill_nxt;
            rec_left  <= rec_nxt;
        end
    end

    // Next state
    always_comb begin
        nxt      = state;
        fill_nxt = dec_sat(fill_left);
        rec_nxt  = dec_sat(rec_left);
        unique case (state)
            LN_SLEEP: begin
                if (run) begin
                    fill_nxt = CW'(FILL - 1);
                    rec_nxt  = CW'(RECOV - 1);
                    nxt      = INSTANT ? LN_LIVE : LN_WAKE;
                end else begin
                    fill_nxt = fill_left;
                    rec_nxt  = rec_left;
                end
            end
            LN_WAKE: begin
                if (!run) begin
                    nxt      = LN_SLEEP;
                    fill_nxt = fill_left;
                    rec_nxt  = rec_left;
                end else if (fill_left <= CW'(1) && rec_left <= CW'(1)) begin
                    nxt = LN_LIVE;
                end
            end
            LN_LIVE: begin
                if (!run) nxt = LN_SLEEP;
            end
            default: nxt = LN_SLEEP;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        capture = run;
        unique case (state)
            LN_LIVE:  valid_out = 1'b1;
            LN_WAKE:  valid_out = 1'b0;
            LN_SLEEP: valid_out = 1'b0;
            default:  valid_out = 1'b0;
        endcase
    end

    // Sample pipeline, format applied as the output register loads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= LAT; i++) pipe[i] <= '0;
        end else if (capture) begin
            pipe[0] <= code_in;
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
            pipe[LAT] <= apply_fmt(pipe[LAT-1], fmt_twos);
        end
    end

    assign data_out = pipe[LAT];

endmodule

// File: rtl/stager_half_cycle.sv
`timescale 1ns/1ps
module stager_half_cycle #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic [W-1:0] d_in,
    input  logic         v_in,
    output logic [W-1:0] d_out,
    output logic         v_out
);

    logic [W-1:0] d_q;
    logic         v_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
        end else begin
            d_q <= d_in;
            v_q <= v_in;
        end
    end

    assign d_out = sel ? d_q : d_in;
    assign v_out = sel ? v_q : v_in;

endmodule

// File: rtl/dual_adc_stager.sv
`timescale 1ns/1ps
module dual_adc_stager #(
    parameter int W     = 8,
    parameter int LAT   = 4,
    parameter int RECOV = 15
) (
    input  logic         enc_a_clk,
    input  logic         enc_b_clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_sel,
    input  logic         fmt_twos,
    input  logic [W-1:0] code_a,
    input  logic [W-1:0] code_b,
    output logic         oe_a,
    output logic [W-1:0] dout_a,
    output logic         valid_a,
    output logic         oe_b,
    output logic [W-1:0] dout_b,
    output logic         valid_b
);

    logic         run_a, run_b, align_b;
    logic [W-1:0] lane_b_q;
    logic         lane_b_v;

    stager_mode_dec u_dec (
        .mode_sel (mode_sel),
        .run_a    (run_a),
        .run_b    (run_b),
        .align_b  (align_b)
    );

    stager_lane #(.W(W), .LAT(LAT), .RECOV(RECOV)) u_lane_a (
        .clk       (enc_a_clk),
        .rst_n     (rst_n),
        .run       (run_a),
        .fmt_twos  (fmt_twos),
        .code_in   (code_a),
        .data_out  (dout_a),
        .valid_out (valid_a)
    );

    stager_lane #(.W(W), .LAT(LAT), .RECOV(RECOV)) u_lane_b (
        .clk       (enc_b_clk),
        .rst_n     (rst_n),
        .run       (run_b),
        .fmt_twos  (fmt_twos),
        .code_in   (code_b),
        .data_out  (lane_b_q),
        .valid_out (lane_b_v)
    );

    stager_half_cycle #(.W(W)) u_retime_b (
        .clk   (enc_b_clk),
        .rst_n (rst_n),
        .sel   (align_b),
        .d_in  (lane_b_q),
        .v_in  (lane_b_v),
        .d_out (dout_b),
        .v_out (valid_b)
    );

    assign oe_a = run_a;
    assign oe_b = run_b;

endmodule

// File: rtl/stager_checker.sv
`timescale 1ns/1ps
module stager_checker #(
    parameter int W     = 8,
    parameter int LAT   = 4,
    parameter int RECOV = 15
) (
    input logic         enc_a_clk,
    input logic         enc_b_clk,
    input logic         rst_n,
    input logic [1:0]   mode_sel,
    input logic         oe_a,
    input logic         oe_b,
    input logic         valid_a,
    input logic [W-1:0] dout_a,
    input logic [W-1:0] dout_b,
    input logic [W-1:0] lane_b_q
);

    logic [7:0] run_cnt;
    int         need;

    // Count encode edges seen awake since reset or the last standby edge
    always_ff @(posedge enc_a_clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            need    <= LAT + 1;
        end else if (!oe_a) begin
            run_cnt <= '0;
            need    <= RECOV;
        end else if (run_cnt != 8'hFF) begin
            run_cnt <= run_cnt + 8'd1;
        end
    end

    assert_hold_in_standby_R8: assert property (@(posedge enc_a_clk) disable iff (!rst_n)
        !oe_a |=> $stable(dout_a));

    assert_valid_drops_R10: assert property (@(posedge enc_a_clk) disable iff (!rst_n)
        !oe_a |=> !valid_a);

    assert_valid_after_count_R9: assert property (@(posedge enc_a_clk) disable iff (!rst_n)
        valid_a |-> (int'(run_cnt) >= need));

    assert_b_off_first_R5: assert property (@(posedge enc_a_clk) disable iff (!rst_n)
        oe_b |-> oe_a);

    assert_half_cycle_R7: assert property (@(negedge enc_b_clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> (mode_sel != 2'b11 || dout_b == $past(lane_b_q)));

endmodule

bind dual_adc_stager stager_checker #(.W(W), .LAT(LAT), .RECOV(RECOV)) u_chk (
    .enc_a_clk (enc_a_clk),
    .enc_b_clk (enc_b_clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .oe_a      (oe_a),
    .oe_b      (oe_b),
    .valid_a   (valid_a),
    .dout_a    (dout_a),
    .dout_b    (dout_b),
    .lane_b_q  (lane_b_q)
);

// File: tb/sim_dual_adc_stager.sv
`timescale 1ns/1ps
module sim_dual_adc_stager;

    logic       enc_a = 1'b0;
    logic       b_inv = 1'b0;
    logic       enc_b;
    logic       rst_n = 1'b1;
    logic [1:0] mode_sel = 2'b10;
    logic       fmt_twos = 1'b0;
    logic [7:0] code_a = '0;
    logic [7:0] code_b = '0;
    logic       oe_a, oe_b, valid_a, valid_b;
    logic [7:0] dout_a, dout_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 enc_a = ~enc_a;   // 250 MHz
    assign enc_b = enc_a ^ b_inv;

    dual_adc_stager u0 (
        .enc_a_clk (enc_a),
        .enc_b_clk (enc_b),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .fmt_twos  (fmt_twos),
        .code_a    (code_a),
        .code_b    (code_b),
        .oe_a      (oe_a),
        .dout_a    (dout_a),
        .valid_a   (valid_a),
        .oe_b      (oe_b),
        .dout_b    (dout_b),
        .valid_b   (valid_b)
    );

    localparam int NV = 7;
    localparam logic [1:0] V_MODE [NV] = '{2'b10, 2'b10, 2'b11, 2'b11, 2'b01, 2'b00, 2'b10};
    localparam bit         V_FMT  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam bit         V_BINV [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [7:0] V_BASE [NV] = '{8'h10, 8'h7C, 8'h30, 8'hF8, 8'h55, 8'h20, 8'hA0};
    localparam bit         V_OEA  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam bit         V_OEB  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam int         V_LAG  [NV] = '{4, 4, 5, 4, 0, 0, 4};
    localparam int         V_MID  [NV] = '{4, 4, 4, 4, 0, 0, 3};

    function automatic logic [7:0] fx(input logic [7:0] c, input bit twos);
        return twos ? (c ^ 8'h80) : c;
    endfunction

    function automatic string b_tag(input logic [1:0] m, input bit inv);
        if (m == 2'b11) return "R7";
        if (m == 2'b10) return inv ? "R12" : "R6";
        if (m == 2'b01) return "R5";
        return "R4";
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge enc_a);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_vec(input int i);
        logic [7:0] ea, eb;
        string bt;
        bt = b_tag(V_MODE[i], V_BINV[i]);
        rst_n    = 1'b0;
        b_inv    = V_BINV[i];
        mode_sel = V_MODE[i];
        fmt_twos = V_FMT[i];
        tick();
        rst_n = 1'b1;
        for (int n = 0; n < 16; n++) begin
            code_a = 8'(V_BASE[i] + n);
            code_b = 8'(V_BASE[i] + 8'h40 + n);
            tick();
            if (n == 3) check("R9", "valid_a before fill", {7'd0, valid_a}, 8'd0);
            if (n == 4) begin
                check(V_OEA[i] ? "R9" : "R4", "valid_a at fill", {7'd0, valid_a}, {7'd0, V_OEA[i]});
                check(V_OEA[i] ? "R1" : "R4", "first sample on A",
                      dout_a, V_OEA[i] ? fx(V_BASE[i], V_FMT[i]) : 8'h00);
            end
            if (n == 12) begin
                ea = V_OEA[i] ? fx(8'(V_BASE[i] + n - 4), V_FMT[i]) : 8'h00;
                eb = (V_LAG[i] == 0) ? 8'h00 : fx(8'(V_BASE[i] + 8'h40 + n - V_LAG[i]), V_FMT[i]);
                check(!V_OEA[i] ? "R4" : (V_FMT[i] ? "R3" : "R2"), "dout_a", dout_a, ea);
                check(bt, "dout_b", dout_b, eb);
                check(bt, "oe_a", {7'd0, oe_a}, {7'd0, V_OEA[i]});
                check(bt, "oe_b", {7'd0, oe_b}, {7'd0, V_OEB[i]});
                check(bt, "valid_b", {7'd0, valid_b}, {7'd0, V_OEB[i]});
            end
        end
        #2;
        eb = (V_MID[i] == 0) ? 8'h00 : fx(8'(V_BASE[i] + 8'h40 + 15 - V_MID[i]), V_FMT[i]);
        check(bt, "dout_b before next A edge", dout_b, eb);
    endtask

    initial begin
        logic [7:0] hold_a, hold_b;
        #1 rst_n = 1'b0;
        #8;
        // R11 reset state
        check("R11", "reset dout_a", dout_a, 8'h00);
        check("R11", "reset dout_b", dout_b, 8'h00);
        check("R11", "reset valid", {6'd0, valid_a, valid_b}, 8'h00);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10 / R8: standby and recovery on a shared clock
        rst_n    = 1'b0;
        b_inv    = 1'b0;
        mode_sel = 2'b10;
        fmt_twos = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            code_a = 8'(8'h90 + k);
            code_b = 8'(8'h60 + k);
            tick();
        end
        check("R10", "valid_a running", {7'd0, valid_a}, 8'd1);
        mode_sel = 2'b00;
        tick();
        check("R10", "valid_a after standby edge", {7'd0, valid_a}, 8'd0);
        check("R4", "oe both low", {6'd0, oe_a, oe_b}, 8'd0);
        hold_a = dout_a;
        hold_b = dout_b;
        for (int k = 0; k < 3; k++) begin
            code_a = 8'(8'h11 * k + 8'h03);
            code_b = 8'(8'h22 * k + 8'h05);
            tick();
        end
        check("R8", "dout_a held in standby", dout_a, hold_a);
        check("R4", "dout_b held in standby", dout_b, hold_b);
        mode_sel = 2'b10;
        for (int k = 1; k <= 15; k++) begin
            code_a = 8'(8'h40 + k);
            code_b = 8'(8'h50 + k);
            tick();
            if (k == 14) check("R10", "valid_a at edge 14", {7'd0, valid_a}, 8'd0);
            if (k == 15) begin
                check("R10", "valid_a at edge 15", {7'd0, valid_a}, 8'd1);
                check("R10", "valid_b at edge 15", {7'd0, valid_b}, 8'd1);
            end
        end

        // R11 asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #0.5;
        check("R11", "async reset dout_a", dout_a, 8'h00);
        check("R11", "async reset valid", {6'd0, valid_a, valid_b}, 8'h00);
        tick();
        rst_n = 1'b1;

        done = 1;
        finish_run();
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

endmodule